// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, a binary weekday, day of month, month and a two-digit year. A fast base tick feeds an internal prescaler. Every `TICKS_PER_SEC` base ticks the seconds field advances, and carries ripple through minutes, hours, day, weekday, month and year in the same clock cycle. The day rollover follows the month length, and February has a 29th day in years divisible by four. Because the year field only counts 00 to 99, this covers every year in range.

A host writes any field through a simple write port, one register per cycle. It reads any field through a combinational read port. A control register selects between a 24-hour and a 12-hour hour format. In 12-hour mode, bit 5 of the hour field acts as a PM flag. Writing the seconds field also restarts the prescaler, so the first increment after setting the clock comes a full second later.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01, year 0x00, and the control register reads 0x00 (24-hour mode).
- R2: The register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 control. Bits that do not exist read as 0: the seconds field keeps bits 6:0, minutes 6:0, hours 5:0, weekday 2:0, day 5:0, month 4:0, year 7:0, and control keeps only bit 0 (1 = 12-hour mode).
- R3: Seconds advance by one BCD step once every `TICKS_PER_SEC` base ticks. Without base ticks or writes, no field changes.
- R4: Seconds 0x59 wrap to 0x00 and advance minutes. Minutes 0x59 wrap to 0x00 and advance hours.
- R5: In 24-hour mode, hours count 0x00 to 0x23. The step from 0x23 wraps to 0x00 and advances the day and the weekday.
- R6: In 12-hour mode, hour bits 4:0 hold BCD 01 to 12 and bit 5 is PM. The step 11 to 12 toggles bit 5, and 12 goes to 01 without toggling. Only the step from PM 11 (0x31) to AM 12 (0x12) advances the day.
- R7: The weekday counts 0 to 6 in binary and wraps from 6 to 0 on each day advance.
- R8: After the last day of the month, the day returns to 0x01 and the month advances. Months 0x04, 0x06, 0x09 and 0x11 end at 0x30, February at 0x28 in a non-leap year, and all others at 0x31.
- R9: February ends at 0x29 when the year value is divisible by four, including 00.
- R10: December 31 is followed by January 1 with the year advanced. Year 0x99 wraps to 0x00.
- R11: A write to seconds loads the value and restarts the prescaler. A base tick in the write cycle is not counted, any seconds increment due in that cycle is dropped, and the next increment comes after exactly `TICKS_PER_SEC` further base ticks.
- R12: A write to a field other than seconds, in a cycle where a second elapses, loads that field with the written value. The other fields advance as they would from their previous values.
- R13: Changing the format bit leaves the stored hour value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | Prescaler input pulse, one cycle wide |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write register address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read register address |
| rd_data | output | 8 | Read data for rd_addr, combinational |

## Verification
A host write and a seconds rollover can land in the same clock cycle. The bench provokes this by advancing the prescaler to one tick short of a second, then raising the base tick together with a write strobe. When the write targets minutes or hours, the bench expects the written field to hold exactly the written value while seconds and the lower fields roll over as usual. When the write targets seconds, it expects the written value with no increment, and the next step only after a full count of base ticks.

// File: rtl/tk_pkg.sv
package tk_pkg;

   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      REG_SEC  = 3'd0,
      REG_MIN  = 3'd1,
      REG_HOUR = 3'd2,
      REG_WDAY = 3'd3,
      REG_DAY  = 3'd4,
      REG_MON  = 3'd5,
      REG_YEAR = 3'd6,
      REG_CTRL = 3'd7
   } tk_reg_e;

   // Year in BCD is divisible by four when 2*tens + units is; only tens[0] matters.
   function automatic logic is_leap(input logic [7:0] yr);
      logic [1:0] s;
      s = yr[1:0] + {yr[4], 1'b0};
      return s == 2'b00;
   endfunction

   function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
   parameter int unsigned TICKS = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_tick,
   input  logic restart,
   output logic step
);
   localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   generate
      if (TICKS < 1) begin : g_bad
         $error("tk_prescaler: TICKS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign step    = base_tick & at_last & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart)   cnt_q <= '0;
      else if (base_tick) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
   end
endmodule

// File: rtl/tk_bcd_step.sv
module tk_bcd_step #(
   parameter int unsigned W = 7
) (
   input  logic         en,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] first,
   input  logic [W-1:0] last,
   output logic [W-1:0] nxt,
   output logic         carry
);
   localparam int unsigned HW = W - 4;

   generate
      if (W < 5 || W > 8) begin : g_bad
         $error("tk_bcd_step: W must lie in 5..8");
      end
   endgenerate

   always_comb begin
      nxt   = cur;
      carry = 1'b0;
      if (en) begin
         if (cur >= last) begin
            nxt   = first;
            carry = 1'b1;
         end else if (cur[3:0] >= 4'h9) begin
            nxt = {cur[W-1:4] + HW'(1), 4'h0};
         end else begin
            nxt = cur + W'(1);
         end
      end
   end
endmodule

// File: rtl/tk_hour_step.sv
module tk_hour_step (
   input  logic       en,
   input  logic       mode12,
   input  logic [5:0] cur,
   output logic [5:0] nxt,
   output logic       carry
);
   logic       pm;
   logic [4:0] h12;

   assign pm  = cur[5];
   assign h12 = cur[4:0];

   always_comb begin
      nxt   = cur;
      carry = 1'b0;
      if (en) begin
         if (!mode12) begin
            if (cur >= 6'h23) begin
               nxt   = 6'h00;
               carry = 1'b1;
            end else if (cur[3:0] >= 4'h9) begin
               nxt = {cur[5:4] + 2'd1, 4'h0};
            end else begin
               nxt = cur + 6'd1;
            end
         end else begin
            if (h12 == 5'h11) begin
               nxt   = {~pm, 5'h12};
               carry = pm;
            end else if (h12 >= 5'h12) begin
               nxt = {pm, 5'h01};
            end else if (h12[3:0] >= 4'h9) begin
               nxt = {pm, 5'h10};
            end else begin
               nxt = {pm, h12 + 5'd1};
            end
         end
      end
   end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
   import tk_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_tick,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   localparam int unsigned NREG = 1 << REG_AW;

   logic [6:0] sec_q, min_q, sec_n, min_n;
   logic [5:0] hr_q, hr_n, day_q, day_n;
   logic [2:0] wd_q, wd_n;
   logic [4:0] mon_q, mon_n;
   logic [7:0] yr_q, yr_n;
   logic       fmt12_q;
   logic       sec_step, restart;
   logic       c_sec, c_min, c_hr, c_day, c_mon, c_yr;
   logic [NREG-1:0] hit;

   assign restart = wr_en && (wr_addr == REG_SEC);
   assign hit     = wr_en ? (NREG'(1) << wr_addr) : '0;

   tk_prescaler #(.TICKS(TICKS_PER_SEC)) u_pre (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
      .restart(restart), .step(sec_step)
   );

   tk_bcd_step #(.W(7)) u_sec (
      .en(sec_step), .cur(sec_q), .first(7'h00), .last(7'h59),
      .nxt(sec_n), .carry(c_sec)
   );
   tk_bcd_step #(.W(7)) u_min (
      .en(c_sec), .cur(min_q), .first(7'h00), .last(7'h59),
      .nxt(min_n), .carry(c_min)
   );
   tk_hour_step u_hr (
      .en(c_min), .mode12(fmt12_q), .cur(hr_q), .nxt(hr_n), .carry(c_hr)
   );
   tk_bcd_step #(.W(6)) u_day (
      .en(c_hr), .cur(day_q), .first(6'h01), .last(last_day(mon_q, yr_q)),
      .nxt(day_n), .carry(c_day)
   );
   tk_bcd_step #(.W(5)) u_mon (
      .en(c_day), .cur(mon_q), .first(5'h01), .last(5'h12),
      .nxt(mon_n), .carry(c_mon)
   );
   tk_bcd_step #(.W(8)) u_yr (
      .en(c_mon), .cur(yr_q), .first(8'h00), .last(8'h99),
      .nxt(yr_n), .carry(c_yr)
   );

   // Weekday is a plain binary modulo-7 counter.
   always_comb begin
      wd_n = wd_q;
      if (c_hr) wd_n = (wd_q >= 3'd6) ? 3'd0 : wd_q + 3'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= 7'h00;
         min_q   <= 7'h00;
         hr_q    <= 6'h00;
         wd_q    <= 3'd0;
         day_q   <= 6'h01;
         mon_q   <= 5'h01;
         yr_q    <= 8'h00;
         fmt12_q <= 1'b0;
      end else begin
         sec_q   <= hit[REG_SEC]  ? wr_data[6:0] : sec_n;
         min_q   <= hit[REG_MIN]  ? wr_data[6:0] : min_n;
         hr_q    <= hit[REG_HOUR] ? wr_data[5:0] : hr_n;
         wd_q    <= hit[REG_WDAY] ? wr_data[2:0] : wd_n;
         day_q   <= hit[REG_DAY]  ? wr_data[5:0] : day_n;
         mon_q   <= hit[REG_MON]  ? wr_data[4:0] : mon_n;
         yr_q    <= hit[REG_YEAR] ? wr_data      : yr_n;
         fmt12_q <= hit[REG_CTRL] ? wr_data[0]   : fmt12_q;
      end
   end

   always_comb begin
      case (rd_addr)
         REG_SEC:  rd_data = {1'b0, sec_q};
         REG_MIN:  rd_data = {1'b0, min_q};
         REG_HOUR: rd_data = {2'b0, hr_q};
         REG_WDAY: rd_data = {5'b0, wd_q};
         REG_DAY:  rd_data = {2'b0, day_q};
         REG_MON:  rd_data = {3'b0, mon_q};
         REG_YEAR: rd_data = yr_q;
         default:  rd_data = {7'b0, fmt12_q};
      endcase
   end

   // The year carry has no destination; fold it into nothing observable.
   logic unused_carry;
   assign unused_carry = c_yr;
endmodule

// File: rtl/tk_checker.sv
module tk_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic [7:0] wr_data,
   input logic       sec_step,
   input logic       fmt12,
   input logic [6:0] sec,
   input logic [6:0] mins,
   input logic [5:0] hr,
   input logic [2:0] wd,
   input logic [5:0] day,
   input logic [4:0] mon,
   input logic [7:0] yr
);
   logic top_of_hour;
   assign top_of_hour = sec_step && !wr_en && sec == 7'h59 && mins == 7'h59;

   a_r11_sec_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd0) |=> sec == $past(wr_data[6:0]));

   a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_step && !wr_en && sec == 7'h59) |=> (sec == 7'h00 && mins != $past(mins)));

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_step && !wr_en) |=> ($stable(sec) && $stable(mins) && $stable(hr) &&
                                 $stable(wd) && $stable(day) && $stable(mon) &&
                                 $stable(yr) && $stable(fmt12)));

   a_r5_midnight_24h: assert property (@(posedge clk) disable iff (!rst_n)
      (top_of_hour && !fmt12 && hr == 6'h23) |=> hr == 6'h00);

   a_r6_noon_flag_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (top_of_hour && fmt12 && hr[4:0] == 5'h11) |=> (hr[4:0] == 5'h12 && hr[5] != $past(hr[5])));

   a_r7_weekday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (top_of_hour && wd == 3'd6 && ((!fmt12 && hr == 6'h23) || (fmt12 && hr == 6'h31)))
         |=> wd == 3'd0);
endmodule

bind bcd_timekeeper tk_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .sec_step(sec_step), .fmt12(fmt12_q), .sec(sec_q), .mins(min_q), .hr(hr_q),
   .wd(wd_q), .day(day_q), .mon(mon_q), .yr(yr_q)
);

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
   localparam int unsigned TPS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bcd_timekeeper #(.TICKS_PER_SEC(TPS)) u_bcd_timekeeper (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      n_chk++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s reg %0d: actual %02h expected %02h", req, a, rd_data, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); base_tick = 1'b1;
         @(negedge clk); base_tick = 1'b0;
      end
   endtask

   // Seconds written last so the prescaler restarts from a known point.
   task automatic set_all(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                          input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
      wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
   endtask

   task automatic t_reset;
      check_reg("R1", 3'd0, 8'h00); check_reg("R1", 3'd1, 8'h00);
      check_reg("R1", 3'd2, 8'h00); check_reg("R1", 3'd3, 8'h00);
      check_reg("R1", 3'd4, 8'h01); check_reg("R1", 3'd5, 8'h01);
      check_reg("R1", 3'd6, 8'h00); check_reg("R1", 3'd7, 8'h00);
   endtask

   task automatic t_masks;
      wr(3'd0, 8'hFF); check_reg("R2", 3'd0, 8'h7F);
      wr(3'd3, 8'hFF); check_reg("R2", 3'd3, 8'h07);
      wr(3'd5, 8'hF2); check_reg("R2", 3'd5, 8'h12);
      wr(3'd7, 8'hFE); check_reg("R2", 3'd7, 8'h00);
      wr(3'd3, 8'h00);
   endtask

   task automatic t_prescale;
      wr(3'd0, 8'h10);
      pulse(TPS - 1); check_reg("R3", 3'd0, 8'h10);
      pulse(1);       check_reg("R3", 3'd0, 8'h11);
      repeat (10) @(negedge clk);
      check_reg("R3", 3'd0, 8'h11);
      pulse(TPS * 3); check_reg("R3", 3'd0, 8'h14);
   endtask

   task automatic t_carry;
      set_all(8'h24, 8'h03, 8'h15, 8'h05, 8'h59, 8'h59);
      pulse(TPS);
      check_reg("R4", 3'd0, 8'h00); check_reg("R4", 3'd1, 8'h00);
      check_reg("R4", 3'd2, 8'h06);
      set_all(8'h24, 8'h03, 8'h15, 8'h09, 8'h59, 8'h59);
      pulse(TPS);
      check_reg("R4", 3'd2, 8'h10);
   endtask

   task automatic t_midnight24;
      wr(3'd7, 8'h00); wr(3'd3, 8'h06);
      set_all(8'h24, 8'h03, 8'h15, 8'h23, 8'h59, 8'h59);
      pulse(TPS);
      check_reg("R5", 3'd2, 8'h00); check_reg("R5", 3'd4, 8'h16);
      check_reg("R7", 3'd3, 8'h00);
      set_all(8'h24, 8'h03, 8'h16, 8'h23, 8'h59, 8'h59);
      pulse(TPS);
      check_reg("R7", 3'd3, 8'h01);
   endtask

   task automatic t_twelve;
      wr(3'd7, 8'h01);
      set_all(8'h24, 8'h03, 8'h10, 8'h11, 8'h59, 8'h59);
      pulse(TPS);
      check_reg("R6", 3'd2, 8'h32); check_reg("R6", 3'd4, 8'h10);
      wr(3'd1, 8'h59); wr(3'd0, 8'h59); pulse(TPS);
      check_reg("R6", 3'd2, 8'h21);
      wr(3'd2, 8'h12); wr(3'd1, 8'h59); wr(3'd0, 8'h59); pulse(TPS);
      check_reg("R6", 3'd2, 8'h01);
      wr(3'd2, 8'h09); wr(3'd1, 8'h59); wr(3'd0, 8'h59); pulse(TPS);
      check_reg("R6", 3'd2, 8'h10);
      wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h59); pulse(TPS);
      check_reg("R6", 3'd2, 8'h12); check_reg("R6", 3'd4, 8'h11);
      wr(3'd7, 8'h00);
   endtask

   task automatic t_months;
      set_all(8'h23, 8'h04, 8'h29, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R8", 3'd4, 8'h30); check_reg("R8", 3'd5, 8'h04);
      set_all(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R8", 3'd4, 8'h01); check_reg("R8", 3'd5, 8'h05);
      set_all(8'h23, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R8", 3'd5, 8'h12);
      set_all(8'h23, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R8", 3'd4, 8'h31);
      set_all(8'h23, 8'h01, 8'h31, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R8", 3'd4, 8'h01); check_reg("R8", 3'd5, 8'h02);
      set_all(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R8", 3'd4, 8'h01); check_reg("R8", 3'd5, 8'h03);
   endtask

   task automatic t_leap;
      set_all(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R9", 3'd4, 8'h29); check_reg("R9", 3'd5, 8'h02);
      wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59); pulse(TPS);
      check_reg("R9", 3'd4, 8'h01); check_reg("R9", 3'd5, 8'h03);
      set_all(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R9", 3'd4, 8'h29);
      set_all(8'h12, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R9", 3'd4, 8'h29);
      set_all(8'h10, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R9", 3'd4, 8'h01); check_reg("R9", 3'd5, 8'h03);
   endtask

   task automatic t_year;
      set_all(8'h41, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R10", 3'd6, 8'h42); check_reg("R10", 3'd5, 8'h01);
      check_reg("R10", 3'd4, 8'h01);
      set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); pulse(TPS);
      check_reg("R10", 3'd6, 8'h00); check_reg("R10", 3'd5, 8'h01);
   endtask

   task automatic t_restart;
      wr(3'd0, 8'h20);
      pulse(TPS - 1);
      @(negedge clk);
      base_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h40;
      @(negedge clk);
      base_tick = 1'b0; wr_en = 1'b0;
      check_reg("R11", 3'd0, 8'h40);
      pulse(TPS - 1); check_reg("R11", 3'd0, 8'h40);
      pulse(1);       check_reg("R11", 3'd0, 8'h41);
   endtask

   task automatic t_collide;
      set_all(8'h24, 8'h03, 8'h15, 8'h05, 8'h10, 8'h59);
      pulse(TPS - 1);
      @(negedge clk);
      base_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h30;
      @(negedge clk);
      base_tick = 1'b0; wr_en = 1'b0;
      check_reg("R12", 3'd0, 8'h00); check_reg("R12", 3'd1, 8'h30);
      set_all(8'h24, 8'h03, 8'h15, 8'h05, 8'h59, 8'h59);
      pulse(TPS - 1);
      @(negedge clk);
      base_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h08;
      @(negedge clk);
      base_tick = 1'b0; wr_en = 1'b0;
      check_reg("R12", 3'd0, 8'h00); check_reg("R12", 3'd1, 8'h00);
      check_reg("R12", 3'd2, 8'h08); check_reg("R12", 3'd4, 8'h15);
   endtask

   task automatic t_mode;
      wr(3'd7, 8'h00); wr(3'd2, 8'h15);
      wr(3'd7, 8'h01);
      check_reg("R13", 3'd2, 8'h15); check_reg("R13", 3'd7, 8'h01);
      wr(3'd7, 8'h00);
      check_reg("R13", 3'd2, 8'h15);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masks();
      t_prescale();
      t_carry();
      t_midnight24();
      t_twelve();
      t_months();
      t_leap();
      t_year();
      t_restart();
      t_collide();
      t_mode();
      summary();
      $finish;
   end
endmodule